// File: doc/BRIEF.md
# Asynchronous Host-Bus Configuration Register Bank

This block connects a host processor's asynchronous, strobe-based bus to a bank of per-channel configuration registers. The bus has an active-low select, active-low write and read strobes, a six-bit address and a 16-bit data path. The block never uses a strobe as a clock. The combined select-and-strobe conditions pass through two-flop synchronizers into the system clock domain. Edge detectors then turn them into single-cycle clock enables for registers that run on the system clock.

The address has two fields. The upper two bits pick one of four channels and the lower four bits pick a field inside that channel. Each channel holds two 32-bit phase increments, one for the code and one for the data, and the host writes each as two 16-bit halves. One shared 16-bit control word sits at field 0 of every channel. Reads go through an AND-OR multiplexer driven by the same decode. The result is captured once when a read access begins, and it is held on the bus until the next read access starts. The system clock must run above three times the strobe rate (100 MHz for 30 ns strobes). The bench uses 200 MHz.

Top module: `hostbus_regbank`

## Requirements
- R1: While reset is applied and after it is released, the control word, every phase increment and the read data are all zero.
- R2: A write access exists only while both the select and the write strobe are low. A write strobe with the select high changes no register.
- R3: A write is committed on the system clock within three clock cycles after the write access ends (strobe or select going high). The address and data used are those present at that moment, and no register changes while the strobe is still low.
- R4: Address bits [5:4] give the channel and bits [3:0] the field. Field 1 writes bits [31:16] and field 2 writes bits [15:0] of that channel's code increment. Field 3 writes bits [31:16] and field 4 writes bits [15:0] of its data increment. No other half or channel is disturbed.
- R5: Field 0 in any channel writes the single shared 16-bit control word, and leaves every increment unchanged.
- R6: A write to fields 5 through 15 of any channel leaves every register unchanged.
- R7: Read data uses the same decode as writes. Field 0 returns the control word, fields 1 to 4 return the halves listed in R4, and fields 5 to 15 return zero.
- R8: Read data is loaded within three clock cycles after a read access begins (select and read strobe both low). It stays stable for the rest of that access and until the next read access begins.
- R9: A read strobe with the select high does not start a read access, so the read data keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_sel_n | input | 1 | Active-low select from the host |
| host_wr_n | input | 1 | Active-low write strobe |
| host_rd_n | input | 1 | Active-low read strobe |
| host_addr | input | 6 | Channel index [5:4] and field offset [3:0] |
| host_wdata | input | 16 | Write data from the host |
| host_rdata | output | 16 | Read data held for the host |
| ctrl_word | output | 16 | Shared control word |
| code_inc | output | 128 | Code phase increments, channel c at bits [32c+31:32c] |
| data_inc | output | 128 | Data phase increments, channel c at bits [32c+31:32c] |

## Verification
Each result has a fixed latency counted in register stages: two synchronizer flops and one edge-detect flop. A committed write therefore shows on the register outputs, and loaded read data on the bus, no later than the third clock edge after the access edge. The bench models a host with 30 ns select-to-strobe setup, 30 ns strobe width and 30 ns hold, which is six clock periods each. It checks register outputs at the last instant the strobe is still low, where they must be unchanged. It checks them again after the 30 ns hold, where the write must be visible. Read data is sampled 20 ns and 30 ns into the strobe, and the two samples must agree with each other and with the model.

// File: rtl/hostbus_regbank_pkg.sv
package hostbus_regbank_pkg;

  // Field offset width inside one channel
  localparam int unsigned OFS_W      = 4;
  // Number of mapped fields per channel (offsets 0 .. NUM_FIELDS-1)
  localparam int unsigned NUM_FIELDS = 5;

  // Field offsets: the host relies on these positions
  localparam int unsigned FLD_CTRL    = 0;
  localparam int unsigned FLD_CODE_HI = 1;
  localparam int unsigned FLD_CODE_LO = 2;
  localparam int unsigned FLD_DATA_HI = 3;
  localparam int unsigned FLD_DATA_LO = 4;

  // Bit positions of the two synchronized access kinds
  localparam int unsigned ACC_WR  = 0;
  localparam int unsigned ACC_RD  = 1;
  localparam int unsigned NUM_ACC = 2;

endpackage

// File: rtl/hb_rst_sync.sv
module hb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sn = stage_q[1];
endmodule

// File: rtl/hb_sync_edge.sv
module hb_sync_edge #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] act_async,
  output logic [WIDTH-1:0] act_begin,
  output logic [WIDTH-1:0] act_end
);
  logic [WIDTH-1:0] meta_q, sync_q, prev_q;
  logic [WIDTH-1:0] meta_d, sync_d, prev_d;

  always_comb begin
    meta_d = act_async;
    sync_d = meta_q;
    prev_d = sync_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= meta_d;
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_edge
    assign act_begin[b] =  sync_q[b] & ~prev_q[b];
    assign act_end[b]   = ~sync_q[b] &  prev_q[b];

    // R3: a commit enable lasts exactly one clock
    a_r3_end_single: assert property (@(posedge clk) disable iff (!rst_n)
      act_end[b] |=> !act_end[b]);
    // R8: a load enable lasts exactly one clock
    a_r8_begin_single: assert property (@(posedge clk) disable iff (!rst_n)
      act_begin[b] |=> !act_begin[b]);
  end
endmodule

// File: rtl/hb_decode.sv
module hb_decode
  import hostbus_regbank_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned CH_W   = $clog2(NUM_CH),
  localparam int unsigned ADDR_W = CH_W + OFS_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     addr,
  output logic [CH_W-1:0]       ch_idx,
  output logic [NUM_FIELDS-1:0] fld_sel
);
  logic [OFS_W-1:0] ofs;

  assign ch_idx = addr[ADDR_W-1:OFS_W];
  assign ofs    = addr[OFS_W-1:0];

  for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_sel
    assign fld_sel[k] = (ofs == OFS_W'(k));
  end

  // R7: decode targets are mutually exclusive, so no priority is needed
  a_r7_sel_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fld_sel));
  // R6: offsets above the mapped range select nothing
  a_r6_unused_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (ofs >= OFS_W'(NUM_FIELDS)) |-> (fld_sel == '0));
endmodule

// File: rtl/hb_regfile.sv
module hb_regfile
  import hostbus_regbank_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned CH_W  = $clog2(NUM_CH),
  localparam int unsigned INC_W = 2 * DATA_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [CH_W-1:0]         ch_idx,
  input  logic [NUM_FIELDS-1:0]   fld_sel,
  input  logic [DATA_W-1:0]       wdata,
  output logic [DATA_W-1:0]       ctrl_o,
  output logic [NUM_CH*INC_W-1:0] code_flat,
  output logic [NUM_CH*INC_W-1:0] data_flat,
  output logic [DATA_W-1:0]       rd_mux
);
  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic [INC_W-1:0]  code_q [NUM_CH];
  logic [INC_W-1:0]  code_d [NUM_CH];
  logic [INC_W-1:0]  data_q [NUM_CH];
  logic [INC_W-1:0]  data_d [NUM_CH];

  // Next state: only the addressed half moves, and only on the commit enable
  always_comb begin
    ctrl_d = ctrl_q;
    for (int c = 0; c < NUM_CH; c++) begin
      code_d[c] = code_q[c];
      data_d[c] = data_q[c];
    end
    if (wr_en) begin
      if (fld_sel[FLD_CTRL]) ctrl_d = wdata;
      for (int c = 0; c < NUM_CH; c++) begin
        if (ch_idx == CH_W'(c)) begin
          if (fld_sel[FLD_CODE_HI]) code_d[c][INC_W-1:DATA_W] = wdata;
          if (fld_sel[FLD_CODE_LO]) code_d[c][DATA_W-1:0]     = wdata;
          if (fld_sel[FLD_DATA_HI]) data_d[c][INC_W-1:DATA_W] = wdata;
          if (fld_sel[FLD_DATA_LO]) data_d[c][DATA_W-1:0]     = wdata;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      for (int c = 0; c < NUM_CH; c++) begin
        code_q[c] <= '0;
        data_q[c] <= '0;
      end
    end else begin
      ctrl_q <= ctrl_d;
      for (int c = 0; c < NUM_CH; c++) begin
        code_q[c] <= code_d[c];
        data_q[c] <= data_d[c];
      end
    end
  end

  // Readback: AND-OR tree over the same exclusive selects
  always_comb begin
    rd_mux = {DATA_W{fld_sel[FLD_CTRL]}} & ctrl_q;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_idx == CH_W'(c)) begin
        rd_mux = rd_mux
               | ({DATA_W{fld_sel[FLD_CODE_HI]}} & code_q[c][INC_W-1:DATA_W])
               | ({DATA_W{fld_sel[FLD_CODE_LO]}} & code_q[c][DATA_W-1:0])
               | ({DATA_W{fld_sel[FLD_DATA_HI]}} & data_q[c][INC_W-1:DATA_W])
               | ({DATA_W{fld_sel[FLD_DATA_LO]}} & data_q[c][DATA_W-1:0]);
      end
    end
  end

  assign ctrl_o = ctrl_q;
  for (genvar g = 0; g < NUM_CH; g++) begin : g_flat
    assign code_flat[g*INC_W +: INC_W] = code_q[g];
    assign data_flat[g*INC_W +: INC_W] = data_q[g];
  end

  // R3: without a commit enable nothing moves
  a_r3_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(ctrl_o) && $stable(code_flat) && $stable(data_flat)));
  // R6: a commit to an unmapped offset moves nothing
  a_r6_unused_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (fld_sel == '0)) |=> ($stable(ctrl_o) && $stable(code_flat) && $stable(data_flat)));
  // R5: a control-word commit leaves the increments alone
  a_r5_ctrl_only: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fld_sel[FLD_CTRL]) |=> ($stable(code_flat) && $stable(data_flat)));
endmodule

// File: rtl/hostbus_regbank.sv
module hostbus_regbank
  import hostbus_regbank_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned CH_W   = $clog2(NUM_CH),
  localparam int unsigned ADDR_W = CH_W + OFS_W,
  localparam int unsigned INC_W  = 2 * DATA_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    host_sel_n,
  input  logic                    host_wr_n,
  input  logic                    host_rd_n,
  input  logic [ADDR_W-1:0]       host_addr,
  input  logic [DATA_W-1:0]       host_wdata,
  output logic [DATA_W-1:0]       host_rdata,
  output logic [DATA_W-1:0]       ctrl_word,
  output logic [NUM_CH*INC_W-1:0] code_inc,
  output logic [NUM_CH*INC_W-1:0] data_inc
);
  logic                  rst_sn;
  logic [NUM_ACC-1:0]    act_async, act_begin, act_end;
  logic [ADDR_W-1:0]     addr_q, addr_d;
  logic [DATA_W-1:0]     wdata_q, wdata_d;
  logic [DATA_W-1:0]     rdata_q, rdata_d;
  logic [DATA_W-1:0]     rd_mux;
  logic [CH_W-1:0]       ch_idx;
  logic [NUM_FIELDS-1:0] fld_sel;
  logic                  commit_en, load_en;

  hb_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  // Active-high access conditions (select and strobe both low)
  assign act_async[ACC_WR] = ~(host_sel_n | host_wr_n);
  assign act_async[ACC_RD] = ~(host_sel_n | host_rd_n);

  hb_sync_edge #(.WIDTH(NUM_ACC)) u_sync (
    .clk       (clk),
    .rst_n     (rst_sn),
    .act_async (act_async),
    .act_begin (act_begin),
    .act_end   (act_end)
  );

  assign commit_en = act_end[ACC_WR];
  assign load_en   = act_begin[ACC_RD];

  // Bus address and data are stable around the enables; register them
  always_comb begin
    addr_d  = host_addr;
    wdata_d = host_wdata;
    rdata_d = load_en ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      rdata_q <= rdata_d;
    end
  end

  hb_decode #(.NUM_CH(NUM_CH)) u_dec (
    .clk     (clk),
    .rst_n   (rst_sn),
    .addr    (addr_q),
    .ch_idx  (ch_idx),
    .fld_sel (fld_sel)
  );

  hb_regfile #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sn),
    .wr_en     (commit_en),
    .ch_idx    (ch_idx),
    .fld_sel   (fld_sel),
    .wdata     (wdata_q),
    .ctrl_o    (ctrl_word),
    .code_flat (code_inc),
    .data_flat (data_inc),
    .rd_mux    (rd_mux)
  );

  assign host_rdata = rdata_q;

  // R8: read data moves only on the load enable
  a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rst_sn)
    !load_en |=> $stable(host_rdata));
  // R9: a read strobe without select never raises the synchronized read
  a_r9_no_read_without_sel: assert property (@(posedge clk) disable iff (!rst_sn)
    (host_sel_n && $past(host_sel_n) && $past(host_sel_n, 2)) |=> !load_en);
endmodule

// File: tb/hostbus_regbank_tb_top.sv
`timescale 1ns/1ps
module hostbus_regbank_tb_top;
  localparam int NCH = 4;

  logic        clk;
  logic        rst_n;
  logic        host_sel_n, host_wr_n, host_rd_n;
  logic [5:0]  host_addr;
  logic [15:0] host_wdata;
  logic [15:0] host_rdata;
  logic [15:0] ctrl_word;
  logic [127:0] code_inc, data_inc;

  int checks = 0;
  int errors = 0;

  logic [15:0] m_ctrl;
  logic [31:0] m_code [NCH];
  logic [31:0] m_data [NCH];

  hostbus_regbank dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_sel_n (host_sel_n),
    .host_wr_n  (host_wr_n),
    .host_rd_n  (host_rd_n),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .ctrl_word  (ctrl_word),
    .code_inc   (code_inc),
    .data_inc   (data_inc)
  );

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_regs(input string req);
    check({req, " ctrl"}, {16'h0, ctrl_word}, {16'h0, m_ctrl});
    for (int c = 0; c < NCH; c++) begin
      check({req, " code"}, code_inc[c*32 +: 32], m_code[c]);
      check({req, " data"}, data_inc[c*32 +: 32], m_data[c]);
    end
  endtask

  function automatic logic [15:0] exp_read(input int ch, input int ofs);
    case (ofs)
      0: return m_ctrl;
      1: return m_code[ch][31:16];
      2: return m_code[ch][15:0];
      3: return m_data[ch][31:16];
      4: return m_data[ch][15:0];
      default: return 16'h0;
    endcase
  endfunction

  // Host write: 30 ns setup, 30 ns strobe, 30 ns hold, 30 ns idle
  task automatic host_write(input logic use_sel, input int ch, input int ofs,
                            input logic [15:0] d, input string req);
    host_addr  = {2'(ch), 4'(ofs)};
    host_wdata = d;
    host_sel_n = ~use_sel;
    #30 host_wr_n = 1'b0;
    #30;
    check_regs("R3 unchanged while strobe low");
    host_wr_n = 1'b1;
    #30;
    if (use_sel) begin
      case (ofs)
        0: m_ctrl = d;
        1: m_code[ch][31:16] = d;
        2: m_code[ch][15:0]  = d;
        3: m_data[ch][31:16] = d;
        4: m_data[ch][15:0]  = d;
        default: ;
      endcase
    end
    check_regs(req);
    host_sel_n = 1'b1;
    #30;
  endtask

  task automatic host_read(input logic use_sel, input int ch, input int ofs,
                           input logic [15:0] exp, input string req);
    logic [15:0] early;
    host_addr  = {2'(ch), 4'(ofs)};
    host_sel_n = ~use_sel;
    #30 host_rd_n = 1'b0;
    #20 early = host_rdata;
    check(req, {16'h0, early}, {16'h0, exp});
    #10 check("R8 read data stable during access", {16'h0, host_rdata}, {16'h0, early});
    host_rd_n = 1'b1;
    #30 check("R8 read data held after access", {16'h0, host_rdata}, {16'h0, early});
    host_sel_n = 1'b1;
    #30;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] last;
    host_sel_n = 1'b1; host_wr_n = 1'b1; host_rd_n = 1'b1;
    host_addr = '0; host_wdata = '0;
    m_ctrl = '0;
    for (int c = 0; c < NCH; c++) begin m_code[c] = '0; m_data[c] = '0; end
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check_regs("R1 during reset");
    check("R1 rdata during reset", {16'h0, host_rdata}, 32'h0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check_regs("R1 after reset");
    check("R1 rdata after reset", {16'h0, host_rdata}, 32'h0);

    // Sweep every channel and every offset
    for (int c = 0; c < NCH; c++) begin
      for (int o = 0; o < 16; o++) begin
        logic [15:0] v;
        v = {4'(c + 1), 4'(o), 8'((c * 16 + o) ^ 8'h5A)};
        if (o == 0)      host_write(1'b1, c, o, v, "R5 control word write");
        else if (o <= 4) host_write(1'b1, c, o, v, "R4 channel half write");
        else             host_write(1'b1, c, o, v, "R6 unused offset ignored");
      end
    end

    // Read back every half-word of every channel
    for (int c = 0; c < NCH; c++) begin
      for (int o = 0; o < 16; o++) begin
        host_read(1'b1, c, o, exp_read(c, o), "R7 readback");
      end
    end

    // Overwrite one half, the other must survive
    host_write(1'b1, 2, 2, 16'hBEEF, "R4 low half overwrite");
    host_read(1'b1, 2, 1, exp_read(2, 1), "R4 high half kept");
    host_read(1'b1, 2, 2, 16'hBEEF, "R7 readback of overwrite");

    // Write strobe with select high: no change
    host_write(1'b0, 1, 3, 16'h1234, "R2 write without select ignored");
    host_write(1'b0, 0, 0, 16'h4321, "R2 control write without select ignored");

    // Read strobe with select high: read data keeps last value
    last = host_rdata;
    host_read(1'b0, 0, 1, last, "R9 read without select ignored");
    host_read(1'b1, 3, 4, exp_read(3, 4), "R7 readback after ignored read");
    host_read(1'b1, 1, 9, 16'h0, "R7 unused offset reads zero");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule